// File: doc/BRIEF.md
# UART Receive Path with Automatic RTS Pacing

This block turns an asynchronous serial stream into bytes and hands them to a host through a 16-entry first-word-fall-through queue. The line is oversampled by an external tick running at sixteen times the bit rate. A falling edge is only taken as a start bit if the line is still low half a bit later; otherwise the receiver drops back to idle. Frames are one start bit, eight data bits sent least significant bit first, and one stop bit. A byte that completes while the queue already holds 16 entries is thrown away, and a sticky overrun flag is raised.

The request-to-send output is active low. When automatic pacing is off, the pin follows a software request bit. When it is on, the pin is driven from the queue occupancy, so a peer whose clear-to-send is wired to it stops before the queue overflows. The low thresholds (1, 4, 8) use hysteresis: the request is withdrawn at the threshold and restored only once the host has drained the queue. The 14 setting reserves the last slot instead. The request is withdrawn once the first data bit of a character is sampled while 15 bytes are already stored. It is restored as soon as stored plus in-flight bytes leave a slot free.

Top module: `uart_rx_autorts`

## Requirements
- R1: After reset the queue is empty (`rx_empty`=1, `fill_level`=0), `overrun` is 0, and the receiver is idle.
- R2: With `tick16` high on every clock, each bit lasts 16 clocks. Data bits are assembled least significant bit first. Completed bytes leave `rd_data` in arrival order, and `rd_data` shows the oldest stored byte.
- R3: A low level on `rx` that has ended before the mid-point of the start bit (8 ticks after detection) stores nothing. The receiver then accepts the next proper frame.
- R4: `trig_sel` encodes the threshold as 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes, 3 = 14 bytes. For 1, 4 and 8 with automatic pacing on, `rts_n` goes to 1 once `fill_level` reaches the threshold, and stays 0 below it.
- R5: For thresholds 1, 4 and 8, `rts_n` returns to 0 only when `fill_level` has been read down to 0.
- R6: For threshold 14, `rts_n` stays 0 with 14 or 15 bytes stored. It goes to 1 within a few clocks after the first data bit of a character arriving with 15 stored has been sampled.
- R7: For threshold 14, `rts_n` returns to 0 once stored bytes plus any byte in flight total at most 15 (for example, after one read from a full queue).
- R8: After `rts_n` has been withdrawn, one further byte is still stored while space remains.
- R9: A byte that completes with 16 bytes stored is discarded. `overrun` goes to 1 and stays 1 until `ovr_clr` is pulsed.
- R10: With `auto_rts_en`=0, `rts_n` equals the inverse of `sw_rts`.
- R11: A read strobe while the queue is empty has no effect on `fill_level`, `rx_empty` or the data that is stored later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Host read strobe, pops the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| rx_empty | output | 1 | Queue holds no bytes |
| fill_level | output | 5 | Number of stored bytes, 0 to 16 |
| trig_sel | input | 2 | Threshold select: 0=1, 1=4, 2=8, 3=14 |
| auto_rts_en | input | 1 | Enables automatic pacing of `rts_n` |
| sw_rts | input | 1 | Software request, used when pacing is off |
| rts_n | output | 1 | Request-to-send, active low |
| overrun | output | 1 | Sticky flag: a byte was discarded |
| ovr_clr | input | 1 | Clears `overrun` |

## Verification
The assertions assume that `trig_sel` and `auto_rts_en` only change while the queue is empty and no frame is in flight. They also assume that `rx` is held steady for whole bit periods. The stimulus sets the threshold only between phases, after the queue has been drained. It drives `rx` in exact 16-clock bit cells, with `tick16` tied high. It never pulses `rd_en` and `ovr_clr` together with a byte completing, so the read and discard rules are each exercised on their own.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // threshold in bytes for each selector code
  function automatic int trig_bytes(input trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

  // true when the threshold uses drain-to-empty hysteresis
  function automatic logic trig_is_low(input trig_e t);
    return (t != TRIG_14);
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  output logic          byte_done,
  output logic [DW-1:0] byte_data,
  output logic          first_bit_evt,
  output logic          in_flight
);
  localparam int CNTW = $clog2(OSR);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNTW-1:0] HALF = CNTW'(OSR / 2 - 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(OSR - 1);
  localparam logic [BW-1:0]   TOPB = BW'(DW - 1);

  logic [1:0]      rx_sync;
  logic            rx_s;
  rx_state_e       state;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]   bitn;
  logic [DW-1:0]   shreg;

  assign rx_s      = rx_sync[1];
  assign byte_data = shreg;
  assign in_flight = (state == RX_DATA && bitn != '0) || state == RX_STOP || byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      cnt           <= '0;
      bitn          <= '0;
      shreg         <= '0;
      byte_done     <= 1'b0;
      first_bit_evt <= 1'b0;
    end else begin
      byte_done     <= 1'b0;
      first_bit_evt <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!rx_s) state <= RX_START;
          end
          RX_START: begin
            if (cnt == HALF) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DW-1:1]};
              if (bitn == '0) first_bit_evt <= 1'b1;
              if (bitn == TOPB) state <= RX_STOP;
              else              bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt == LAST) begin
              cnt       <= '0;
              byte_done <= 1'b1;
              state     <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick && cnt == HALF && rx_s) |=> (state == RX_IDLE && !first_bit_evt));

  assert_done_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_done) |-> $past(state == RX_STOP));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full     = (count == CFULL);
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign drop     = push && full;
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CFULL);

  assert_drop_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/uart_rx_rtsctl.sv
module uart_rx_rtsctl
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  trig_e                      trig,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic                       in_flight,
  input  logic                       first_bit_evt,
  output logic                       rts_off
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW:0] occ;
  logic        low_mode;
  logic        at_trig;

  assign occ      = {1'b0, fill} + (CW + 1)'(in_flight);
  assign low_mode = trig_is_low(trig);
  assign at_trig  = int'(fill) >= trig_bytes(trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_off <= 1'b0;
    end else if (low_mode) begin
      if (at_trig)          rts_off <= 1'b1;
      else if (fill == '0)  rts_off <= 1'b0;
    end else begin
      rts_off <= (occ >= (CW + 1)'(DEPTH));
    end
  end

  assert_low_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_mode && $past(low_mode) && $fell(rts_off)) |-> $past(fill == '0));

  assert_late_withdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_mode && $past(!low_mode) && $rose(rts_off) && $past(fill) < CW'(DEPTH)) |-> $past(in_flight));

endmodule

// File: rtl/uart_rx_autorts.sv
module uart_rx_autorts
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       rx,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       rx_empty,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  input  logic [1:0]                 trig_sel,
  input  logic                       auto_rts_en,
  input  logic                       sw_rts,
  output logic                       rts_n,
  output logic                       overrun,
  input  logic                       ovr_clr
);
  logic          byte_done;
  logic [DW-1:0] byte_data;
  logic          first_bit_evt;
  logic          in_flight;
  logic          q_full;
  logic          q_drop;
  logic          rts_off;

  uart_rx_deser #(.OSR(OSR), .DW(DW)) u_deser (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick16),
    .rx            (rx),
    .byte_done     (byte_done),
    .byte_data     (byte_data),
    .first_bit_evt (first_bit_evt),
    .in_flight     (in_flight)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (byte_done),
    .push_data (byte_data),
    .pop       (rd_en),
    .pop_data  (rd_data),
    .count     (fill_level),
    .full      (q_full),
    .empty     (rx_empty),
    .drop      (q_drop)
  );

  uart_rx_rtsctl #(.DEPTH(DEPTH)) u_rts (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig          (trig_e'(trig_sel)),
    .fill          (fill_level),
    .in_flight     (in_flight),
    .first_bit_evt (first_bit_evt),
    .rts_off       (rts_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (q_drop)  overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assign rts_n = auto_rts_en ? rts_off : !sw_rts;

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(q_full && byte_done));

endmodule

// File: tb/sim_uart_rx_autorts.sv
module sim_uart_rx_autorts;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       rx = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_empty;
  logic [4:0] fill_level;
  logic [1:0] trig_sel = 2'd0;
  logic       auto_rts_en = 1'b0;
  logic       sw_rts = 1'b0;
  logic       rts_n;
  logic       overrun;
  logic       ovr_clr = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_autorts u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .rd_en(rd_en),
    .rd_data(rd_data), .rx_empty(rx_empty), .fill_level(fill_level),
    .trig_sel(trig_sel), .auto_rts_en(auto_rts_en), .sw_rts(sw_rts),
    .rts_n(rts_n), .overrun(overrun), .ovr_clr(ovr_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one 8N1 frame; the byte is queued as expected when it will be kept
  task automatic send_byte(input logic [7:0] b, input bit keep);
    if (keep) exp_q.push_back(b);
    @(negedge clk) rx = 1'b0;
    repeat (BIT_CLKS - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rx = b[i];
      repeat (BIT_CLKS - 1) @(negedge clk);
    end
    @(negedge clk) rx = 1'b1;
    repeat (BIT_CLKS - 1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop one byte and compare with the scoreboard
  task automatic read_byte(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk(req, rd_data, e);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", rx_empty, 1);
    chk("R1 fill", fill_level, 0);
    chk("R1 overrun", overrun, 0);
    // R10 software request
    chk("R10 sw_rts=0", rts_n, 1);
    sw_rts = 1'b1;
    @(negedge clk);
    chk("R10 sw_rts=1", rts_n, 0);

    // R11 read on empty ignored
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    @(negedge clk);
    chk("R11 fill", fill_level, 0);
    chk("R11 empty", rx_empty, 1);

    // threshold 1
    auto_rts_en = 1'b1; trig_sel = 2'd0;
    @(negedge clk);
    chk("R4 t1 idle", rts_n, 0);
    send_byte(8'hA5, 1);
    chk("R2 fill after one", fill_level, 1);
    chk("R4 t1 withdrawn", rts_n, 1);
    send_byte(8'h3C, 1);
    chk("R8 extra byte kept", fill_level, 2);
    chk("R8 no overrun", overrun, 0);
    read_byte("R2 t1 data0");
    chk("R5 t1 held at 1", rts_n, 1);
    read_byte("R2 t1 data1");
    chk("R5 t1 released", rts_n, 0);

    // threshold 4
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send_byte(8'(8'h10 + i * 8'h21), 1);
    chk("R4 t4 below", rts_n, 0);
    send_byte(8'h81, 1);
    chk("R4 t4 at", rts_n, 1);
    for (int i = 0; i < 3; i++) read_byte("R2 t4 data");
    chk("R5 t4 still held", rts_n, 1);
    read_byte("R2 t4 last");
    chk("R5 t4 released", rts_n, 0);

    // threshold 8
    trig_sel = 2'd2;
    for (int i = 0; i < 7; i++) send_byte(8'(8'hF0 ^ (i * 8'h13)), 1);
    chk("R4 t8 below", rts_n, 0);
    send_byte(8'h00, 1);
    chk("R4 t8 at", rts_n, 1);
    for (int i = 0; i < 8; i++) read_byte("R2 t8 data");
    chk("R5 t8 released", rts_n, 0);

    // R3 false start
    @(negedge clk) rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 nothing stored", fill_level, 0);
    send_byte(8'h5A, 1);
    chk("R3 next frame stored", fill_level, 1);
    read_byte("R3 data");

    // threshold 14
    trig_sel = 2'd3;
    for (int i = 0; i < 14; i++) send_byte(8'(8'h40 + i * 8'h07), 1);
    chk("R6 held at 14", rts_n, 0);
    send_byte(8'hC3, 1);
    chk("R6 held at 15", rts_n, 0);
    fork
      send_byte(8'h96, 1);
      begin
        repeat (12) @(negedge clk);
        chk("R6 before first data bit", rts_n, 0);
        repeat (28) @(negedge clk);
        chk("R6 after first data bit", rts_n, 1);
      end
    join
    chk("R8 sixteenth kept", fill_level, 16);
    chk("R6 full withdrawn", rts_n, 1);
    send_byte(8'hEE, 0);
    chk("R9 discard fill", fill_level, 16);
    chk("R9 overrun set", overrun, 1);
    repeat (5) @(negedge clk);
    chk("R9 overrun sticky", overrun, 1);
    read_byte("R2 t14 data");
    chk("R7 one slot free", rts_n, 0);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    @(negedge clk);
    chk("R9 overrun cleared", overrun, 0);
    for (int i = 0; i < 15; i++) read_byte("R2 t14 data");
    chk("R2 drained", rx_empty, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule